// File: doc/BRIEF.md
# Programmable Glitch Debounce Filter

This block conditions one asynchronous digital input before the rest of the chip sees it. The raw level is first brought into the clock domain by a two-stage synchronizer. A filter then decides when the output level may follow the synchronized input. The filter waits out a programmable timeout equal to a small count multiplied by one of four tick units. It can time both edges, or only one edge so that short pulses of the other polarity pass straight through.

The base tick comes from a free-running divider of the block clock, set by a parameter. Two independent select bits choose how many base ticks make one unit of the count. A mode value of zero turns the filter off, and the synchronized input then reaches the output directly. The configured fields are echoed on a registered readback word.

Top module: `glitch_filter`

## Requirements
- R1: While reset is held and on the first cycle after it, `pinOut` is 0 and `cfgRb` is 0.
- R2: With `fltMode` = 2'b00 (bypass), `pinOut` equals the value `pinRaw` had three rising clock edges earlier, so a one-cycle pulse also appears at the output.
- R3: With `fltMode` = 2'b01 (both edges timed), `pinOut` takes a new level only after the synchronized input has held that level for `cntField` x unit base ticks. A shorter pulse of either polarity never reaches the output.
- R4: While a timed change is pending, any cycle in which the synchronized input returns to the current output level discards the elapsed time. The next attempt must wait the full timeout again.
- R5: The unit per count is chosen by `{largeSel, unitSel}`: 2'b00 gives UNIT_A, 2'b01 gives UNIT_B, 2'b10 gives UNIT_C and 2'b11 gives UNIT_D base ticks. One base tick lasts TICK_DIV clock cycles.
- R6: With `fltMode` = 2'b10 (low pulses kept), a falling input reaches `pinOut` three edges after `pinRaw` falls, even for a one-cycle low pulse. A rising input is timed as in R3.
- R7: With `fltMode` = 2'b11 (high pulses kept), a rising input reaches `pinOut` three edges after `pinRaw` rises, even for a one-cycle high pulse. A falling input is timed as in R3.
- R8: In any filtering mode, `cntField` = 0 means a zero timeout, so both edges reach `pinOut` three edges after `pinRaw` changes, whatever unit is selected.
- R9: One clock after the fields are applied, `cfgRb` = {`fltMode`[1:0], `largeSel`, `unitSel`, `cntField`}, with `cntField` in the low bits.
- R10: The largest setting (`cntField` all ones, `{largeSel, unitSel}` = 2'b11) gives a timeout of 15 x UNIT_D base ticks. The timer neither wraps nor cuts the wait short.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; also drives the base-tick divider |
| rstN | input | 1 | Active-low synchronous reset |
| pinRaw | input | 1 | Asynchronous pin level to be filtered |
| cntField | input | CNT_W | Timeout count in units |
| unitSel | input | 1 | Picks the longer of the two units within the range |
| largeSel | input | 1 | Picks the long-range pair of units |
| fltMode | input | 2 | 00 bypass, 01 both edges timed, 10 keep low pulses, 11 keep high pulses |
| pinOut | output | 1 | Filtered level |
| cfgRb | output | CNT_W+4 | Registered readback of the configured fields |

## Verification
The hardest case to reach from the ports is the restart of a pending timeout. Only a return of the input to the output level, lasting exactly one synchronized cycle, can discard elapsed time without ever letting the output move. The stimulus drives two pulses, each just shorter than the timeout, separated by a single-cycle return. Their combined length is well past the timeout, so a filter that failed to restart would flip the output, and the watch that follows would catch it. Because the tick divider runs freely, every timed check samples one tick period before the earliest possible change and again after the latest.

// File: rtl/gf_pkg.sv
package gf_pkg;

  typedef enum logic [1:0] {
    MODE_PASS    = 2'b00,
    MODE_BOTH    = 2'b01,
    MODE_KEEP_LO = 2'b10,
    MODE_KEEP_HI = 2'b11
  } fltMode_e;

  typedef struct packed {
    logic timerClr;
    logic timerStep;
    logic outLoad;
  } gfStrobe_t;

endpackage

// File: rtl/gf_datapath.sv
module gf_datapath
  import gf_pkg::*;
#(
  parameter int TICK_DIV = 200,
  parameter int UNIT_A   = 61,
  parameter int UNIT_B   = 244,
  parameter int UNIT_C   = 15625,
  parameter int UNIT_D   = 62500,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinRaw,
  input  logic [CNT_W-1:0] cntField,
  input  logic             unitSel,
  input  logic             largeSel,
  input  logic [1:0]       fltMode,
  input  gfStrobe_t        strb,
  output logic             syncIn,
  output logic             tick,
  output logic             timerDone,
  output logic             pinOut,
  output logic [CNT_W+3:0] cfgRb
);

  localparam int UNIT_AB  = (UNIT_A > UNIT_B) ? UNIT_A : UNIT_B;
  localparam int UNIT_CD  = (UNIT_C > UNIT_D) ? UNIT_C : UNIT_D;
  localparam int UNIT_MAX = (UNIT_AB > UNIT_CD) ? UNIT_AB : UNIT_CD;
  localparam int LIMIT_W  = $clog2(((2 ** CNT_W) - 1) * UNIT_MAX + 1);

  logic [1:0]         syncFf;
  logic [LIMIT_W-1:0] unitTicks;
  logic [LIMIT_W-1:0] limit;
  logic [LIMIT_W-1:0] timer;

  // two-stage synchronizer for the asynchronous pin
  always_ff @(posedge clk) begin
    if (!rstN) syncFf <= '0;
    else       syncFf <= {syncFf[0], pinRaw};
  end
  assign syncIn = syncFf[1];

  // base tick: every cycle, or one cycle in TICK_DIV
  generate
    if (TICK_DIV <= 1) begin : g_tickAll
      assign tick = 1'b1;
    end else begin : g_tickDiv
      localparam int DIV_W = $clog2(TICK_DIV);
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk) begin
        if (!rstN)                              divCnt <= '0;
        else if (divCnt == DIV_W'(TICK_DIV - 1)) divCnt <= '0;
        else                                    divCnt <= divCnt + 1'b1;
      end
      assign tick = (divCnt == DIV_W'(TICK_DIV - 1));
    end
  endgenerate

  always_comb begin
    case ({largeSel, unitSel})
      2'b00:   unitTicks = LIMIT_W'(UNIT_A);
      2'b01:   unitTicks = LIMIT_W'(UNIT_B);
      2'b10:   unitTicks = LIMIT_W'(UNIT_C);
      default: unitTicks = LIMIT_W'(UNIT_D);
    endcase
  end

  assign limit     = LIMIT_W'(cntField) * unitTicks;
  assign timerDone = (timer >= limit);

  always_ff @(posedge clk) begin
    if (!rstN)               timer <= '0;
    else if (strb.timerClr)  timer <= '0;
    else if (strb.timerStep) timer <= timer + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             pinOut <= 1'b0;
    else if (strb.outLoad) pinOut <= syncIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) cfgRb <= '0;
    else       cfgRb <= {fltMode, largeSel, unitSel, cntField};
  end

  // R10: the timer is never advanced past its limit
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.timerStep |-> (timer < limit));

  // R4: agreement between input and output wipes any elapsed time
  assert_restart_R4: assert property (@(posedge clk) disable iff (!rstN)
    (syncIn == pinOut) |=> (timer == '0));

endmodule

// File: rtl/gf_control.sv
module gf_control
  import gf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] fltMode,
  input  logic       syncIn,
  input  logic       pinOut,
  input  logic       tick,
  input  logic       timerDone,
  output gfStrobe_t  strb
);

  fltMode_e modeE;
  logic     fastEdge;

  assign modeE    = fltMode_e'(fltMode);
  assign fastEdge = ((modeE == MODE_KEEP_LO) && !syncIn) ||
                    ((modeE == MODE_KEEP_HI) &&  syncIn);

  always_comb begin
    strb = '0;
    if (modeE == MODE_PASS) begin
      strb.timerClr = 1'b1;
      strb.outLoad  = (syncIn != pinOut);
    end else if (syncIn == pinOut) begin
      strb.timerClr = 1'b1;
    end else if (fastEdge || timerDone) begin
      strb.outLoad  = 1'b1;
      strb.timerClr = 1'b1;
    end else if (tick) begin
      strb.timerStep = 1'b1;
    end
  end

  // R4: clearing and advancing the timer never coincide
  assert_clr_step_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.timerClr && strb.timerStep));

endmodule

// File: rtl/glitch_filter.sv
module glitch_filter
  import gf_pkg::*;
#(
  parameter int TICK_DIV = 200,
  parameter int UNIT_A   = 61,
  parameter int UNIT_B   = 244,
  parameter int UNIT_C   = 15625,
  parameter int UNIT_D   = 62500,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinRaw,
  input  logic [CNT_W-1:0] cntField,
  input  logic             unitSel,
  input  logic             largeSel,
  input  logic [1:0]       fltMode,
  output logic             pinOut,
  output logic [CNT_W+3:0] cfgRb
);

  gfStrobe_t strb;
  logic      syncIn;
  logic      tick;
  logic      timerDone;

  gf_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .fltMode   (fltMode),
    .syncIn    (syncIn),
    .pinOut    (pinOut),
    .tick      (tick),
    .timerDone (timerDone),
    .strb      (strb)
  );

  gf_datapath #(
    .TICK_DIV (TICK_DIV),
    .UNIT_A   (UNIT_A),
    .UNIT_B   (UNIT_B),
    .UNIT_C   (UNIT_C),
    .UNIT_D   (UNIT_D),
    .CNT_W    (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .pinRaw    (pinRaw),
    .cntField  (cntField),
    .unitSel   (unitSel),
    .largeSel  (largeSel),
    .fltMode   (fltMode),
    .strb      (strb),
    .syncIn    (syncIn),
    .tick      (tick),
    .timerDone (timerDone),
    .pinOut    (pinOut),
    .cfgRb     (cfgRb)
  );

  // R2: bypass copies the synchronized level on the next edge
  assert_bypass_follow_R2: assert property (@(posedge clk) disable iff (!rstN)
    (fltMode == 2'b00) |=> (pinOut == $past(syncIn)));

  // R3: in both-edge mode an output change needs an expired timer
  assert_both_timed_R3: assert property (@(posedge clk) disable iff (!rstN)
    (($past(fltMode) == 2'b01) && (pinOut != $past(pinOut))) |-> $past(timerDone));

  // R6: with low pulses kept, only a rise is timed
  assert_keep_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    (($past(fltMode) == 2'b10) && $rose(pinOut)) |-> $past(timerDone));

  // R7: with high pulses kept, only a fall is timed
  assert_keep_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    (($past(fltMode) == 2'b11) && $fell(pinOut)) |-> $past(timerDone));

endmodule

// File: tb/glitch_filter_test.sv
`timescale 1ns/1ps
module glitch_filter_test;

  localparam int D  = 2;
  localparam int UA = 1;
  localparam int UB = 2;
  localparam int UC = 3;
  localparam int UD = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pinRaw = 1'b0;
  logic [3:0] cntField = '0;
  logic       unitSel = 1'b0;
  logic       largeSel = 1'b0;
  logic [1:0] fltMode = 2'b00;
  logic       pinOut;
  logic [7:0] cfgRb;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  glitch_filter #(
    .TICK_DIV (D), .UNIT_A (UA), .UNIT_B (UB), .UNIT_C (UC), .UNIT_D (UD), .CNT_W (4)
  ) uut (
    .clk (clk), .rstN (rstN), .pinRaw (pinRaw), .cntField (cntField),
    .unitSel (unitSel), .largeSel (largeSel), .fltMode (fltMode),
    .pinOut (pinOut), .cfgRb (cfgRb)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setCfg(input logic [1:0] m, input logic l, input logic u,
                        input logic [3:0] c);
    fltMode = m; largeSel = l; unitSel = u; cntField = c;
  endtask

  task automatic settle(input logic lvl);
    setCfg(2'b00, 1'b0, 1'b0, 4'd0);
    pinRaw = lvl;
    cyc(4);
    setCfg(2'b00, 1'b0, 1'b0, 4'd0);
  endtask

  task automatic holdSteady(input int n, input logic exp, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pinOut !== exp) bad++;
    end
    check(bad == 0, req, "output held through pulse", bad, 0);
  endtask

  // drive a new level and check it appears inside the timeout window
  task automatic timedEdge(input logic lvl, input int ticks, input string req);
    pinRaw = lvl;
    if (ticks == 0) begin
      cyc(2);
      check(pinOut !== lvl, req, "zero timeout early", pinOut, !lvl);
      cyc(1);
      check(pinOut === lvl, req, "zero timeout edge", pinOut, lvl);
    end else begin
      cyc((ticks - 1) * D + 3);
      check(pinOut !== lvl, req, "before timeout", pinOut, !lvl);
      cyc(D);
      check(pinOut === lvl, req, "after timeout", pinOut, lvl);
    end
  endtask

  task automatic testReset();
    check(pinOut === 1'b0, "R1", "pinOut after reset", pinOut, 0);
    check(cfgRb === 8'h00, "R1", "cfgRb after reset", cfgRb, 0);
  endtask

  task automatic testBypass();
    settle(1'b0);
    pinRaw = 1'b1;
    cyc(2);
    check(pinOut === 1'b0, "R2", "bypass rise too early", pinOut, 0);
    cyc(1);
    check(pinOut === 1'b1, "R2", "bypass rise", pinOut, 1);
    pinRaw = 1'b0;
    cyc(1);
    pinRaw = 1'b1;
    cyc(2);
    check(pinOut === 1'b0, "R2", "one-cycle low pulse seen", pinOut, 0);
    cyc(1);
    check(pinOut === 1'b1, "R2", "after low pulse", pinOut, 1);
  endtask

  task automatic testBoth();
    settle(1'b0);
    setCfg(2'b01, 1'b0, 1'b0, 4'd3);
    cyc(2);
    pinRaw = 1'b1; cyc(4); pinRaw = 1'b0;
    holdSteady(20, 1'b0, "R3");
    timedEdge(1'b1, 3, "R3");
    cyc(4);
    pinRaw = 1'b0; cyc(4); pinRaw = 1'b1;
    holdSteady(20, 1'b1, "R3");
    timedEdge(1'b0, 3, "R3");
  endtask

  task automatic testRestart();
    settle(1'b0);
    setCfg(2'b01, 1'b0, 1'b1, 4'd4);
    cyc(2);
    pinRaw = 1'b1; cyc(14);
    pinRaw = 1'b0; cyc(1);
    pinRaw = 1'b1; cyc(14);
    pinRaw = 1'b0;
    holdSteady(20, 1'b0, "R4");
    timedEdge(1'b1, 8, "R4");
  endtask

  task automatic testUnits();
    settle(1'b0);
    setCfg(2'b01, 1'b0, 1'b0, 4'd2); cyc(2);
    timedEdge(1'b1, 2 * UA, "R5");
    setCfg(2'b01, 1'b0, 1'b1, 4'd2); cyc(2);
    timedEdge(1'b0, 2 * UB, "R5");
    setCfg(2'b01, 1'b1, 1'b0, 4'd2); cyc(2);
    timedEdge(1'b1, 2 * UC, "R5");
    setCfg(2'b01, 1'b1, 1'b1, 4'd2); cyc(2);
    timedEdge(1'b0, 2 * UD, "R5");
  endtask

  task automatic testKeepLow();
    settle(1'b1);
    setCfg(2'b10, 1'b0, 1'b0, 4'd3);
    cyc(2);
    pinRaw = 1'b0; cyc(1); pinRaw = 1'b1; cyc(2);
    check(pinOut === 1'b0, "R6", "one-cycle low pulse passes", pinOut, 0);
    cyc(20);
    check(pinOut === 1'b1, "R6", "recovered high", pinOut, 1);
    pinRaw = 1'b0; cyc(5);
    check(pinOut === 1'b0, "R6", "fall immediate", pinOut, 0);
    pinRaw = 1'b1; cyc(4); pinRaw = 1'b0;
    holdSteady(15, 1'b0, "R6");
    timedEdge(1'b1, 3, "R6");
  endtask

  task automatic testKeepHigh();
    settle(1'b0);
    setCfg(2'b11, 1'b0, 1'b0, 4'd3);
    cyc(2);
    pinRaw = 1'b1; cyc(1); pinRaw = 1'b0; cyc(2);
    check(pinOut === 1'b1, "R7", "one-cycle high pulse passes", pinOut, 1);
    cyc(20);
    check(pinOut === 1'b0, "R7", "recovered low", pinOut, 0);
    pinRaw = 1'b1; cyc(5);
    check(pinOut === 1'b1, "R7", "rise immediate", pinOut, 1);
    pinRaw = 1'b0; cyc(4); pinRaw = 1'b1;
    holdSteady(15, 1'b1, "R7");
    timedEdge(1'b0, 3, "R7");
  endtask

  task automatic testZeroCount();
    settle(1'b0);
    setCfg(2'b01, 1'b0, 1'b0, 4'd0); cyc(2);
    timedEdge(1'b1, 0, "R8");
    timedEdge(1'b0, 0, "R8");
    setCfg(2'b01, 1'b1, 1'b1, 4'd0); cyc(2);
    timedEdge(1'b1, 0, "R8");
  endtask

  task automatic testReadback();
    setCfg(2'b10, 1'b1, 1'b0, 4'hA);
    cyc(1);
    check(cfgRb === 8'hAA, "R9", "readback word", cfgRb, 8'hAA);
    setCfg(2'b11, 1'b0, 1'b1, 4'h5);
    cyc(1);
    check(cfgRb === 8'hD5, "R9", "readback word", cfgRb, 8'hD5);
  endtask

  task automatic testMax();
    settle(1'b0);
    setCfg(2'b01, 1'b1, 1'b1, 4'hF); cyc(2);
    timedEdge(1'b1, 15 * UD, "R10");
    timedEdge(1'b0, 15 * UD, "R10");
  endtask

  initial begin
    rstN = 1'b0;
    cyc(3);
    check(pinOut === 1'b0, "R1", "pinOut during reset", pinOut, 0);
    rstN = 1'b1;
    cyc(1);
    testReset();
    testBypass();
    testBoth();
    testRestart();
    testUnits();
    testKeepLow();
    testKeepHigh();
    testZeroCount();
    testReadback();
    testMax();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule